// File: doc/BRIEF.md
# Paged Speech Store/Play Sequencer

This block sequences two independent single-bit sample streams through a bit-addressed memory that is divided into fixed-size pages. The store channel writes encoder bits into memory and the play channel reads bits back for the decoder. Each channel takes 16-bit commands that name a start page and a page count. On every sample tick of an active channel, the block presents one memory bit address and a request. It does not model memory timing: a request is a single-cycle strobe that is valid together with the tick.

Each channel holds one running command and a one-deep buffer. An immediate command takes over at once. A buffered command waits, then starts with no gap when the running command completes. Optionally it waits for the other channel to complete instead, which keeps store and play in lockstep for time-domain scrambling. Completion raises a per-channel flag and, if enabled, the interrupt line. Play can walk its pages backwards. When no play command runs, the decoder receives an alternating idle pattern.

Top module: `speech_page_seq`

## Requirements
- R1: A command word carries the page count minus one in bits 15:12 (0000 means one page, 1111 means sixteen) and the start page X in bits 11:0. A command covers N pages of 2^PAGE_LOG2 bits each.
- R2: In forward order the first request addresses bit X·2^PAGE_LOG2 of the address space. Each further tick of the channel addresses the next bit, wrapping modulo 2^ADDR_W. A request (`mem_wr_req`/`mem_rd_req`) is high exactly in the tick cycles of an active channel, and `mem_wr_bit` equals `enc_bit`.
- R3: When `cfg_play_reverse` is high at the moment a play command starts, that command addresses from the last bit of page X+N−1 down to the first bit of page X. The direction is latched per command, and the store channel always runs forward.
- R4: A command loaded with `*_cmd_imm` high becomes the running command at the next clock edge and abandons the current one. The buffer is left untouched, and the sync mode does not delay it.
- R5: A buffered command is kept in a one-deep buffer, and a later buffered load overwrites it. With sync off for that channel, it starts at the edge that completes the running command, so with ticks every cycle there is no gap. If the channel is idle, it starts at the next edge.
- R6: `*_done` pulses in the tick cycle of a command's final bit. The matching `*_complete` flag is set from the next cycle. Any command load on that channel clears the flag, and a load in the same cycle as completion leaves the flag clear.
- R7: `irq` is high while (`st_complete` and `cfg_store_irq_en`) or (`pl_complete` and `cfg_play_irq_en`).
- R8: `cfg_sync` = 01 makes a buffered play command start only at the edge where a store completes. `cfg_sync` = 10 makes a buffered store command start only where a play completes. In these modes the gated channel's own completion does not start it. The values 00 and 11 leave both channels independent.
- R9: While play is idle, `dec_bit` alternates 0,1,0,1 on successive play ticks, starting at 0 after reset and after every play completion. While play is active, `dec_bit` equals `mem_rd_bit`.
- R10: After reset there are no requests, no done pulses, both flags and `irq` are low, and both buffers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sync | input | 2 | Cross-channel start gating mode |
| cfg_play_reverse | input | 1 | Play direction for the next play start (1 = descending) |
| cfg_store_irq_en | input | 1 | Store completion interrupt enable |
| cfg_play_irq_en | input | 1 | Play completion interrupt enable |
| st_tick | input | 1 | Store sample tick |
| st_cmd_valid | input | 1 | Store command load strobe |
| st_cmd_imm | input | 1 | Store command is immediate (1) or buffered (0) |
| st_cmd_word | input | CMD_W | Store command word |
| pl_tick | input | 1 | Play sample tick |
| pl_cmd_valid | input | 1 | Play command load strobe |
| pl_cmd_imm | input | 1 | Play command is immediate (1) or buffered (0) |
| pl_cmd_word | input | CMD_W | Play command word |
| enc_bit | input | 1 | Encoder output bit |
| mem_wr_req | output | 1 | Write one bit this cycle |
| mem_wr_addr | output | ADDR_W | Write bit address |
| mem_wr_bit | output | 1 | Bit to write |
| mem_rd_req | output | 1 | Read one bit this cycle |
| mem_rd_addr | output | ADDR_W | Read bit address |
| mem_rd_bit | input | 1 | Bit returned by memory in the same cycle |
| dec_bit | output | 1 | Bit to the decoder, valid with `pl_tick` |
| st_done | output | 1 | Store command completion pulse |
| pl_done | output | 1 | Play command completion pulse |
| st_complete | output | 1 | Store complete flag |
| pl_complete | output | 1 | Play complete flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with PAGE_LOG2 = 3, so a page is 8 bits, while keeping the 12-bit page index and 4-bit count. Sixteen-page commands then finish in 128 ticks, and completion, chaining and both sync gates occur many times within a short run. Address wrap at page 4095 is driven directly. Random sync, direction and enable changes are mixed with commands that collide with completions.

// File: rtl/sps_pkg.sv
package sps_pkg;
   typedef enum logic [1:0] {
      SYNC_OFF       = 2'b00,
      SYNC_PLAY_GATE = 2'b01,
      SYNC_STORE_GATE= 2'b10,
      SYNC_OFF_ALT   = 2'b11
   } sync_e;

   localparam int CH_STORE = 0;
   localparam int CH_PLAY  = 1;
endpackage

// File: rtl/sps_channel.sv
module sps_channel #(
   parameter int PAGE_LOG2   = 10,
   parameter int PAGE_IDX_W  = 12,
   parameter int CNT_W       = 4,
   parameter bit CAN_REVERSE = 1'b0,
   localparam int CMD_W  = CNT_W + PAGE_IDX_W,
   localparam int ADDR_W = PAGE_IDX_W + PAGE_LOG2,
   localparam int REM_W  = CNT_W + PAGE_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cmd_valid,
   input  logic              cmd_imm,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              rev_req,
   input  logic              gated,
   input  logic              partner_done,
   output logic              busy,
   output logic              req,
   output logic [ADDR_W-1:0] addr,
   output logic              done,
   output logic              complete
);
   logic              active_q;
   logic [ADDR_W-1:0] addr_q;
   logic [REM_W-1:0]  rem_q;
   logic              dir_q;
   logic              buf_v_q;
   logic [CMD_W-1:0]  buf_w_q;
   logic              cmp_q;

   logic              take_imm, launch, start, consume, dir_sel;
   logic [CMD_W-1:0]  sel_w;
   logic [CNT_W-1:0]  sel_n;
   logic [PAGE_IDX_W-1:0] sel_x;
   logic [REM_W-1:0]  span;
   logic [ADDR_W-1:0] lo_addr, hi_addr, step_addr;

   generate
      if (CAN_REVERSE) begin : g_rev
         assign dir_sel = rev_req;
      end else begin : g_fwd
         logic unused_rev;
         assign unused_rev = rev_req;
         assign dir_sel    = 1'b0;
      end
   endgenerate

   always_comb begin
      done     = active_q & tick & (rem_q == '0);
      take_imm = cmd_valid & cmd_imm;
      launch   = buf_v_q & (gated ? partner_done : (~active_q | done));
      start    = take_imm | launch;
      consume  = launch & ~take_imm;
      sel_w    = take_imm ? cmd_word : buf_w_q;
      sel_n    = sel_w[CMD_W-1 -: CNT_W];
      sel_x    = sel_w[PAGE_IDX_W-1:0];
      span     = {sel_n, {PAGE_LOG2{1'b1}}};
      lo_addr  = {sel_x, {PAGE_LOG2{1'b0}}};
      hi_addr  = lo_addr + ADDR_W'(span);
      step_addr = dir_q ? (addr_q - ADDR_W'(1)) : (addr_q + ADDR_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         addr_q   <= '0;
         rem_q    <= '0;
         dir_q    <= 1'b0;
      end else if (start) begin
         active_q <= 1'b1;
         addr_q   <= dir_sel ? hi_addr : lo_addr;
         rem_q    <= span;
         dir_q    <= dir_sel;
      end else if (active_q && tick) begin
         if (done) begin
            active_q <= 1'b0;
         end else begin
            addr_q <= step_addr;
            rem_q  <= rem_q - REM_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_v_q <= 1'b0;
         buf_w_q <= '0;
      end else if (cmd_valid && !cmd_imm) begin
         buf_v_q <= 1'b1;
         buf_w_q <= cmd_word;
      end else if (consume) begin
         buf_v_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp_q <= 1'b0;
      else if (cmd_valid) cmp_q <= 1'b0;
      else if (done)      cmp_q <= 1'b1;
   end

   assign busy     = active_q;
   assign req      = active_q & tick;
   assign addr     = addr_q;
   assign complete = cmp_q;
endmodule

// File: rtl/sps_idle_pattern.sv
module sps_idle_pattern (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic busy,
   input  logic mem_bit,
   output logic dec_bit
);
   logic phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    phase_q <= 1'b0;
      else if (busy) phase_q <= 1'b0;
      else if (tick) phase_q <= ~phase_q;
   end

   assign dec_bit = busy ? mem_bit : phase_q;
endmodule

// File: rtl/speech_page_seq.sv
module speech_page_seq
   import sps_pkg::*;
#(
   parameter int PAGE_LOG2  = 10,
   parameter int PAGE_IDX_W = 12,
   parameter int CNT_W      = 4,
   localparam int CMD_W  = CNT_W + PAGE_IDX_W,
   localparam int ADDR_W = PAGE_IDX_W + PAGE_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_sync,
   input  logic              cfg_play_reverse,
   input  logic              cfg_store_irq_en,
   input  logic              cfg_play_irq_en,
   input  logic              st_tick,
   input  logic              st_cmd_valid,
   input  logic              st_cmd_imm,
   input  logic [CMD_W-1:0]  st_cmd_word,
   input  logic              pl_tick,
   input  logic              pl_cmd_valid,
   input  logic              pl_cmd_imm,
   input  logic [CMD_W-1:0]  pl_cmd_word,
   input  logic              enc_bit,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic              mem_wr_bit,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_bit,
   output logic              dec_bit,
   output logic              st_done,
   output logic              pl_done,
   output logic              st_complete,
   output logic              pl_complete,
   output logic              irq
);
   generate
      if (PAGE_LOG2 < 1 || CNT_W < 1 || PAGE_IDX_W < CNT_W) begin : g_bad_cfg
         $error("speech_page_seq: PAGE_LOG2, CNT_W must be >= 1 and PAGE_IDX_W >= CNT_W");
      end
   endgenerate

   sync_e sync_mode;
   logic  st_gated, pl_gated;
   logic  unused_st_busy, pl_busy;

   assign sync_mode = sync_e'(cfg_sync);
   assign st_gated  = (sync_mode == SYNC_STORE_GATE);
   assign pl_gated  = (sync_mode == SYNC_PLAY_GATE);

   sps_channel #(
      .PAGE_LOG2(PAGE_LOG2), .PAGE_IDX_W(PAGE_IDX_W), .CNT_W(CNT_W), .CAN_REVERSE(1'b0)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .tick(st_tick),
      .cmd_valid(st_cmd_valid), .cmd_imm(st_cmd_imm), .cmd_word(st_cmd_word),
      .rev_req(1'b0), .gated(st_gated), .partner_done(pl_done),
      .busy(unused_st_busy), .req(mem_wr_req), .addr(mem_wr_addr),
      .done(st_done), .complete(st_complete)
   );

   sps_channel #(
      .PAGE_LOG2(PAGE_LOG2), .PAGE_IDX_W(PAGE_IDX_W), .CNT_W(CNT_W), .CAN_REVERSE(1'b1)
   ) u_play (
      .clk(clk), .rst_n(rst_n), .tick(pl_tick),
      .cmd_valid(pl_cmd_valid), .cmd_imm(pl_cmd_imm), .cmd_word(pl_cmd_word),
      .rev_req(cfg_play_reverse), .gated(pl_gated), .partner_done(st_done),
      .busy(pl_busy), .req(mem_rd_req), .addr(mem_rd_addr),
      .done(pl_done), .complete(pl_complete)
   );

   sps_idle_pattern u_idle (
      .clk(clk), .rst_n(rst_n), .tick(pl_tick), .busy(pl_busy),
      .mem_bit(mem_rd_bit), .dec_bit(dec_bit)
   );

   assign mem_wr_bit = enc_bit;
   assign irq = (st_complete & cfg_store_irq_en) | (pl_complete & cfg_play_irq_en);
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
   parameter int ADDR_W = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              st_cmd_valid,
   input logic              pl_cmd_valid,
   input logic              pl_tick,
   input logic              mem_wr_req,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic              mem_rd_req,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              dec_bit,
   input logic              st_done,
   input logic              pl_done,
   input logic              st_complete,
   input logic              pl_complete,
   input logic              irq
);
   logic              wr_v, rd_v, idle_v, idle_last;
   logic [ADDR_W-1:0] wr_next, rd_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_v <= 1'b0; wr_next <= '0;
         rd_v <= 1'b0; rd_last <= '0;
         idle_v <= 1'b0; idle_last <= 1'b0;
      end else begin
         if (st_cmd_valid || st_done || pl_done) wr_v <= 1'b0;
         else if (mem_wr_req) begin
            wr_v <= 1'b1; wr_next <= mem_wr_addr + ADDR_W'(1);
         end
         if (pl_cmd_valid || pl_done || st_done) rd_v <= 1'b0;
         else if (mem_rd_req) begin
            rd_v <= 1'b1; rd_last <= mem_rd_addr;
         end
         if (mem_rd_req) idle_v <= 1'b0;
         else if (pl_tick) begin
            idle_v <= 1'b1; idle_last <= dec_bit;
         end
      end
   end

   p_done_on_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_done |-> mem_wr_req);
   p_done_on_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pl_done |-> mem_rd_req);
   p_st_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_done && !st_cmd_valid) |=> st_complete);
   p_pl_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_done && !pl_cmd_valid) |=> pl_complete);
   p_st_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_cmd_valid |=> !st_complete);
   p_pl_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pl_cmd_valid |=> !pl_complete);
   p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (st_complete || pl_complete));
   p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && wr_v) |-> (mem_wr_addr == wr_next));
   p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && rd_v) |->
         (mem_rd_addr == rd_last + ADDR_W'(1) || mem_rd_addr == rd_last - ADDR_W'(1)));
   p_idle_alt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_tick && !mem_rd_req && idle_v) |-> (dec_bit != idle_last));
endmodule

bind speech_page_seq sps_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .st_cmd_valid(st_cmd_valid), .pl_cmd_valid(pl_cmd_valid),
   .pl_tick(pl_tick), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
   .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .dec_bit(dec_bit),
   .st_done(st_done), .pl_done(pl_done), .st_complete(st_complete),
   .pl_complete(pl_complete), .irq(irq)
);

// File: tb/speech_page_seq_tb.sv
`timescale 1ns/100ps
module speech_page_seq_tb;
   localparam int L    = 3;
   localparam int P    = 1 << L;
   localparam int IDXW = 12;
   localparam int CW   = 4;
   localparam int AW   = IDXW + L;
   localparam int MASK = (1 << AW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cfg_sync = 2'b00;
   logic cfg_play_reverse = 1'b0, cfg_store_irq_en = 1'b0, cfg_play_irq_en = 1'b0;
   logic st_tick = 1'b0, st_cmd_valid = 1'b0, st_cmd_imm = 1'b0;
   logic [15:0] st_cmd_word = '0;
   logic pl_tick = 1'b0, pl_cmd_valid = 1'b0, pl_cmd_imm = 1'b0;
   logic [15:0] pl_cmd_word = '0;
   logic enc_bit = 1'b0, mem_rd_bit = 1'b0;
   logic mem_wr_req, mem_wr_bit, mem_rd_req, dec_bit;
   logic [AW-1:0] mem_wr_addr, mem_rd_addr;
   logic st_done, pl_done, st_complete, pl_complete, irq;

   always #2.5 clk = ~clk;

   speech_page_seq #(.PAGE_LOG2(L), .PAGE_IDX_W(IDXW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_play_reverse(cfg_play_reverse),
      .cfg_store_irq_en(cfg_store_irq_en), .cfg_play_irq_en(cfg_play_irq_en),
      .st_tick(st_tick), .st_cmd_valid(st_cmd_valid), .st_cmd_imm(st_cmd_imm),
      .st_cmd_word(st_cmd_word), .pl_tick(pl_tick), .pl_cmd_valid(pl_cmd_valid),
      .pl_cmd_imm(pl_cmd_imm), .pl_cmd_word(pl_cmd_word), .enc_bit(enc_bit),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_bit(mem_wr_bit),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_bit(mem_rd_bit),
      .dec_bit(dec_bit), .st_done(st_done), .pl_done(pl_done),
      .st_complete(st_complete), .pl_complete(pl_complete), .irq(irq)
   );

   int nchk = 0, nerr = 0;
   bit finished = 1'b0;
   string phase = "R10 reset";

   // reference model state, index 0 = store, 1 = play
   bit m_act[2], m_rev[2], m_bv[2], m_cmp[2];
   int m_x[2], m_n[2], m_k[2];
   logic [15:0] m_bw[2];
   bit m_ph;

   function automatic int exp_addr(int c);
      if (m_rev[c]) return (((m_x[c] + m_n[c]) * P) - 1 - m_k[c]) & MASK;
      return (m_x[c] * P + m_k[c]) & MASK;
   endfunction

   task automatic chk(string rq, string fld, int got, int exp);
      nchk++;
      if (got != exp) begin
         nerr++;
         $display("FAIL %s %s [%s]: got %0d expected %0d", rq, fld, phase, got, exp);
      end
   endtask

   task automatic step(bit ts, bit tp, bit scv, bit sci, logic [15:0] sw,
                       bit pcv, bit pci, logic [15:0] pw);
      bit tk[2], cv[2], ci[2], ed[2], g[2];
      logic [15:0] cw[2];
      st_tick = ts; pl_tick = tp;
      st_cmd_valid = scv; st_cmd_imm = sci; st_cmd_word = sw;
      pl_cmd_valid = pcv; pl_cmd_imm = pci; pl_cmd_word = pw;
      enc_bit = 1'($urandom_range(0, 1));
      mem_rd_bit = 1'($urandom_range(0, 1));
      tk[0] = ts; tk[1] = tp; cv[0] = scv; cv[1] = pcv;
      ci[0] = sci; ci[1] = pci; cw[0] = sw; cw[1] = pw;
      #1;
      for (int c = 0; c < 2; c++)
         ed[c] = m_act[c] && tk[c] && (m_k[c] == m_n[c] * P - 1);
      chk("R2", "wr_req", int'(mem_wr_req), int'(m_act[0] && tk[0]));
      if (m_act[0] && tk[0]) begin
         chk("R2", "wr_addr", int'(mem_wr_addr), exp_addr(0));
         chk("R2", "wr_bit", int'(mem_wr_bit), int'(enc_bit));
      end
      chk("R2", "rd_req", int'(mem_rd_req), int'(m_act[1] && tk[1]));
      if (m_act[1] && tk[1])
         chk(m_rev[1] ? "R3" : "R2", "rd_addr", int'(mem_rd_addr), exp_addr(1));
      chk("R9", "dec_bit", int'(dec_bit), int'(m_act[1] ? mem_rd_bit : m_ph));
      chk("R6", "st_done", int'(st_done), int'(ed[0]));
      chk("R6", "pl_done", int'(pl_done), int'(ed[1]));
      chk("R6", "st_complete", int'(st_complete), int'(m_cmp[0]));
      chk("R6", "pl_complete", int'(pl_complete), int'(m_cmp[1]));
      chk("R7", "irq", int'(irq),
          int'((m_cmp[0] && cfg_store_irq_en) || (m_cmp[1] && cfg_play_irq_en)));
      // model update (R1, R4, R5, R8 rules)
      g[0] = (cfg_sync == 2'b10);
      g[1] = (cfg_sync == 2'b01);
      if (m_act[1]) m_ph = 1'b0;
      else if (tk[1]) m_ph = ~m_ph;
      for (int c = 0; c < 2; c++) begin
         bit imm, launch;
         logic [15:0] w;
         imm    = cv[c] && ci[c];
         launch = m_bv[c] && (g[c] ? ed[1-c] : (!m_act[c] || ed[c]));
         if (imm || launch) begin
            w = imm ? cw[c] : m_bw[c];
            m_act[c] = 1'b1;
            m_x[c] = int'(w[11:0]);
            m_n[c] = int'(w[15:12]) + 1;
            m_k[c] = 0;
            m_rev[c] = (c == 1) ? cfg_play_reverse : 1'b0;
         end else if (m_act[c] && tk[c]) begin
            if (ed[c]) m_act[c] = 1'b0;
            else m_k[c]++;
         end
         if (cv[c] && !ci[c]) begin
            m_bv[c] = 1'b1; m_bw[c] = cw[c];
         end else if (launch && !imm) m_bv[c] = 1'b0;
         if (cv[c]) m_cmp[c] = 1'b0;
         else if (ed[c]) m_cmp[c] = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run(int n, bit ts, bit tp);
      for (int i = 0; i < n; i++) step(ts, tp, 0, 0, '0, 0, 0, '0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      for (int c = 0; c < 2; c++) begin
         m_act[c] = 0; m_rev[c] = 0; m_bv[c] = 0; m_cmp[c] = 0;
         m_x[c] = 0; m_n[c] = 1; m_k[c] = 0; m_bw[c] = '0;
      end
      m_ph = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      phase = "R10 reset";
      run(3, 0, 0);
      run(4, 0, 1);

      phase = "R1 one page code 0000";
      step(1, 0, 1, 1, {4'd0, 12'd5}, 0, 0, '0);
      run(12, 1, 0);

      phase = "R4 immediate takeover";
      step(0, 1, 0, 0, '0, 1, 1, {4'd1, 12'd2});
      run(5, 0, 1);
      step(0, 1, 0, 0, '0, 1, 1, {4'd0, 12'd100});
      run(12, 0, 1);

      phase = "R5 buffered chaining";
      step(1, 0, 1, 1, {4'd0, 12'd7}, 0, 0, '0);
      step(1, 0, 1, 0, {4'd0, 12'd9}, 0, 0, '0);
      run(20, 1, 0);
      step(0, 0, 1, 0, {4'd1, 12'd20}, 0, 0, '0);
      run(20, 1, 0);

      phase = "R3 reverse play";
      cfg_play_reverse = 1'b1;
      step(0, 1, 0, 0, '0, 1, 1, {4'd2, 12'd10});
      cfg_play_reverse = 1'b0;
      run(30, 0, 1);

      phase = "R8 play after store";
      cfg_sync = 2'b01;
      step(1, 1, 1, 1, {4'd0, 12'd60}, 1, 1, {4'd3, 12'd50});
      step(1, 1, 0, 0, '0, 1, 0, {4'd0, 12'd70});
      run(20, 1, 1);
      step(0, 1, 0, 0, '0, 1, 0, {4'd0, 12'd80});
      run(30, 0, 1);
      step(1, 1, 1, 1, {4'd0, 12'd1}, 0, 0, '0);
      run(20, 1, 1);

      phase = "R8 store after play";
      cfg_sync = 2'b10;
      step(1, 1, 1, 1, {4'd2, 12'd30}, 1, 1, {4'd0, 12'd31});
      step(1, 1, 1, 0, {4'd0, 12'd40}, 0, 0, '0);
      run(30, 1, 1);
      cfg_sync = 2'b11;
      step(1, 1, 1, 1, {4'd0, 12'd3}, 0, 0, '0);
      step(1, 1, 1, 0, {4'd0, 12'd4}, 0, 0, '0);
      run(20, 1, 1);
      cfg_sync = 2'b00;

      phase = "R7 interrupt enables";
      cfg_store_irq_en = 1'b1;
      step(1, 0, 1, 1, {4'd0, 12'd3}, 0, 0, '0);
      run(12, 1, 0);
      cfg_play_irq_en = 1'b1; cfg_store_irq_en = 1'b0;
      step(0, 1, 0, 0, '0, 1, 1, {4'd0, 12'd6});
      run(12, 0, 1);
      cfg_play_irq_en = 1'b0;
      run(2, 0, 0);

      phase = "R2 wrap at top page";
      step(1, 0, 1, 1, {4'd1, 12'd4095}, 0, 0, '0);
      run(20, 1, 0);

      phase = "R9 idle pattern";
      run(10, 0, 1);
      run(3, 0, 0);
      run(5, 0, 1);

      phase = "random";
      for (int i = 0; i < 6000; i++) begin
         bit scv, pcv;
         if (i % 500 == 0) begin
            cfg_sync = 2'($urandom_range(0, 3));
            cfg_play_reverse = 1'($urandom_range(0, 1));
            cfg_store_irq_en = 1'($urandom_range(0, 1));
            cfg_play_irq_en = 1'($urandom_range(0, 1));
         end
         scv = ($urandom_range(0, 39) == 0);
         pcv = ($urandom_range(0, 39) == 0);
         step($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
              scv, 1'($urandom_range(0, 1)),
              {4'($urandom_range(0, 3)), 12'($urandom_range(0, 4095))},
              pcv, 1'($urandom_range(0, 1)),
              {4'($urandom_range(0, 3)), 12'($urandom_range(0, 4095))});
         if (i % 1000 == 0) cfg_play_reverse = 1'($urandom_range(0, 1));
      end
      finish_run();
   end
endmodule